// File: doc/BRIEF.md
# Power-Gated Secure Domain Control Register

This block is a single memory-mapped control and status word for a secure memory domain that can be power gated. Software reaches it over a simple register bus with one address, a write strobe, write data and a registered read data path. The word selects between automatic and manual control of two power switches, one high-impedance and one low-impedance. It also holds the secure IP in reset, requests a test mode, and carries a permanent kill bit that survives everything except a chip reset.

In automatic mode a small sequencer brings the domain up after reset: it closes the high-impedance switch, waits for a number of clock cycles supplied on a fuse input, then closes the low-impedance switch and flags completion. In manual mode the two switch bits drive the switches as written, and software owns the wait between them. Two read-only status bits report whether both switches are closed. An external write-protect input blocks every write while it is high.

Top module: `pgd_ctrl_reg`

## Requirements
- R1: After reset the word at the register address reads 0x00000148, both switch outputs are 0, `ip_rst` is 1, `ip_test` is 0 and `ip_clk_en`/`ip_sel_en` are 1.
- R2: A write while `wp_en` is 1 changes no control bit and no output.
- R3: With bit 0 clear the high-Z switch turns on first and the low-Z switch turns on exactly `fuse_dly`+1 clock cycles later; `seq_done` rises in the same cycle as the low-Z switch.
- R4: With bit 0 set, bit 1 drives the high-Z switch and bit 2 drives the low-Z switch with no enforced order.
- R5: Bit 9 reads 1 only when both switch outputs are on; otherwise bit 9 reads 0 and bit 8 reads 1. Writes to bits 9:8 have no effect.
- R6: Bit 4 (disable) can be set by a write but never cleared by one; only `rst` clears it.
- R7: While bit 4 is set, both switch outputs, `ip_clk_en` and `ip_sel_en` are 0, and the sequencer returns to its off state.
- R8: `ip_rst` follows bit 3; `ip_test` is 1 only when bit 5 is 1, bit 3 is 0 and bit 4 is 0.
- R9: Bit 6 always reads 1 whatever is written, bit 7 and bits 31:10 read 0, and any other address reads 0.
- R10: `bus_rdata` is registered: it reflects the addressed word one clock after the address is presented; control outputs change one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| wp_en | input | 1 | Write-protect enable from the protection register |
| fuse_dly | input | DLY_W | Switch-to-switch delay in clock cycles |
| sw_hiz_on | output | 1 | High-impedance power switch enable |
| sw_loz_on | output | 1 | Low-impedance power switch enable |
| seq_done | output | 1 | Automatic power-up sequence complete |
| ip_rst | output | 1 | Reset to the secure IP |
| ip_test | output | 1 | Test-mode request to the secure IP |
| ip_clk_en | output | 1 | Clock enable to the secure IP |
| ip_sel_en | output | 1 | Bus-select enable to the secure IP |

## Verification
The bench measures the gap between the two switch turn-ons for two fuse values, so a sequencer that is off by one cycle or that closes both switches together shows up as a wrong gap. It writes the disable bit and then tries to clear it, so a design that treats the bit as ordinary read/write keeps the domain powered; a further chip reset must bring it back. It writes low-Z alone in manual mode and writes with protection set, catching designs that impose ordering in manual mode or let protected writes through, and it writes ones into the reserved and status bit positions to catch read data that leaks them. The test-mode request is probed with the IP reset bit both set and clear.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

  typedef struct packed {
    logic tmode;
    logic kill;
    logic iprst;
    logic loz;
    logic hiz;
    logic manual;
  } pgd_ctl_t;

  localparam int unsigned CTL_W = 6;
  localparam int unsigned ONE_BIT = 6;
  localparam int unsigned PLO_BIT = 8;
  localparam int unsigned PHI_BIT = 9;

  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_ON   = 2'd2
  } pgd_seq_e;

endpackage

// File: rtl/pgd_ctl_bits.sv
module pgd_ctl_bits
  import pgd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             wp_en,
  input  logic [CTL_W-1:0] wbits,
  output pgd_ctl_t         ctl
);

  pgd_ctl_t ctl_q;
  pgd_ctl_t wr_v;

  assign wr_v = pgd_ctl_t'(wbits);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '{tmode: 1'b0, kill: 1'b0, iprst: 1'b1, loz: 1'b0, hiz: 1'b0, manual: 1'b0};
    end else if (wr_hit && !wp_en) begin
      ctl_q.tmode  <= wr_v.tmode;
      ctl_q.kill   <= ctl_q.kill | wr_v.kill;
      ctl_q.iprst  <= wr_v.iprst;
      ctl_q.loz    <= wr_v.loz;
      ctl_q.hiz    <= wr_v.hiz;
      ctl_q.manual <= wr_v.manual;
    end
  end

  assign ctl = ctl_q;

  assert_kill_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ctl_q.kill |=> ctl_q.kill);

  assert_wp_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wp_en) |=> $stable(ctl_q));

endmodule

// File: rtl/pgd_pwr_seq.sv
module pgd_pwr_seq
  import pgd_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic [DLY_W-1:0] dly,
  output logic             hiz,
  output logic             loz,
  output logic             done
);

  pgd_seq_e         st_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      st_q  <= SQ_OFF;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_OFF: begin
          st_q  <= SQ_WAIT;
          cnt_q <= dly;
        end
        SQ_WAIT: begin
          if (cnt_q == '0) st_q <= SQ_ON;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= SQ_ON;
      endcase
    end
  end

  assign hiz  = (st_q == SQ_WAIT) || (st_q == SQ_ON);
  assign loz  = (st_q == SQ_ON);
  assign done = (st_q == SQ_ON);

  assert_loz_after_hiz_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_WAIT) |=> (st_q != SQ_OFF) || $past(kill));

  assert_kill_resets_seq_R7: assert property (@(posedge clk) disable iff (rst)
    kill |=> (st_q == SQ_OFF));

endmodule

// File: rtl/pgd_ctrl_reg.sv
module pgd_ctrl_reg
  import pgd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DLY_W  = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wp_en,
  input  logic [DLY_W-1:0]  fuse_dly,
  output logic              sw_hiz_on,
  output logic              sw_loz_on,
  output logic              seq_done,
  output logic              ip_rst,
  output logic              ip_test,
  output logic              ip_clk_en,
  output logic              ip_sel_en
);

  localparam int unsigned USED_W = PHI_BIT + 1;

  logic     hit;
  pgd_ctl_t ctl;
  logic     sq_hiz, sq_loz, sq_done;
  logic     nxt_hiz, nxt_loz;
  logic     pwr_hi;
  logic [USED_W-1:0] word;
  logic     unused_wdata;

  assign hit = (bus_addr == REG_ADDR);
  assign unused_wdata = ^bus_wdata[DATA_W-1:CTL_W];

  pgd_ctl_bits u_bits (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (hit && bus_we),
    .wp_en  (wp_en),
    .wbits  (bus_wdata[CTL_W-1:0]),
    .ctl    (ctl)
  );

  pgd_pwr_seq #(.DLY_W(DLY_W)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .kill (ctl.kill),
    .dly  (fuse_dly),
    .hiz  (sq_hiz),
    .loz  (sq_loz),
    .done (sq_done)
  );

  always_comb begin
    if (ctl.kill) begin
      nxt_hiz = 1'b0;
      nxt_loz = 1'b0;
    end else if (ctl.manual) begin
      nxt_hiz = ctl.hiz;
      nxt_loz = ctl.loz;
    end else begin
      nxt_hiz = sq_hiz;
      nxt_loz = sq_loz;
    end
  end

  assign pwr_hi = sw_hiz_on && sw_loz_on;

  always_comb begin
    word = '0;
    word[CTL_W-1:0] = ctl;
    word[ONE_BIT]   = 1'b1;
    word[PLO_BIT]   = !pwr_hi;
    word[PHI_BIT]   = pwr_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_hiz_on <= 1'b0;
      sw_loz_on <= 1'b0;
      seq_done  <= 1'b0;
      ip_rst    <= 1'b1;
      ip_test   <= 1'b0;
      ip_clk_en <= 1'b1;
      ip_sel_en <= 1'b1;
      bus_rdata <= '0;
    end else begin
      sw_hiz_on <= nxt_hiz;
      sw_loz_on <= nxt_loz;
      seq_done  <= sq_done && !ctl.kill;
      ip_rst    <= ctl.iprst;
      ip_test   <= ctl.tmode && !ctl.iprst && !ctl.kill;
      ip_clk_en <= !ctl.kill;
      ip_sel_en <= !ctl.kill;
      bus_rdata <= hit ? DATA_W'(word) : '0;
    end
  end

  assert_kill_gates_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.kill |=> (!sw_hiz_on && !sw_loz_on && !ip_clk_en && !ip_sel_en));

  assert_test_gated_R8: assert property (@(posedge clk) disable iff (rst)
    ip_test |-> (!ip_rst && ip_clk_en));

  assert_auto_order_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctl.manual && sw_loz_on) |-> sw_hiz_on);

  assert_done_with_loz_R3: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (ctl.manual || sw_loz_on));

endmodule

// File: tb/pgd_ctrl_reg_tb.sv
module pgd_ctrl_reg_tb_top;

  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;
  localparam int unsigned LW = 8;
  localparam logic [AW-1:0] RA = 12'h200;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          wp_en;
  logic [LW-1:0] fuse_dly;
  logic sw_hiz_on, sw_loz_on, seq_done, ip_rst, ip_test, ip_clk_en, ip_sel_en;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pgd_ctrl_reg #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(LW), .REG_ADDR(RA)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_en(wp_en),
    .fuse_dly(fuse_dly), .sw_hiz_on(sw_hiz_on), .sw_loz_on(sw_loz_on),
    .seq_done(seq_done), .ip_rst(ip_rst), .ip_test(ip_test),
    .ip_clk_en(ip_clk_en), .ip_sel_en(ip_sel_en)
  );

  typedef struct packed {
    logic        wp;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        hiz;
    logic        loz;
    logic        rs;
    logic        tst;
    logic        cke;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0041, 32'h0000_0141, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 manual, off
    '{1'b0, 32'h0000_0043, 32'h0000_0143, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 R5 high-Z only
    '{1'b0, 32'h0000_0047, 32'h0000_0247, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 both on
    '{1'b0, 32'h0000_0067, 32'h0000_0267, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R8 test allowed
    '{1'b0, 32'h0000_006F, 32'h0000_026F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R8 test blocked
    '{1'b1, 32'h0000_0005, 32'h0000_026F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R2 protected
    '{1'b0, 32'h0000_0005, 32'h0000_0145, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 R9 low-Z alone
    '{1'b0, 32'hFFFF_FF87, 32'h0000_0247, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 R5 reserved ones
    '{1'b0, 32'h0000_0057, 32'h0000_0157, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 disable
    '{1'b0, 32'h0000_0047, 32'h0000_0157, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R6 no clear
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic p);
    @(negedge clk);
    bus_we = 1'b1; bus_wdata = d; wp_en = p;
    @(negedge clk);
    bus_we = 1'b0; wp_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset word", bus_rdata, 32'h0000_0148);
    chk("R1 switches off", {30'b0, sw_hiz_on, sw_loz_on}, 32'h0);
    chk("R1 ip_rst/test/clk/sel", {28'b0, ip_rst, ip_test, ip_clk_en, ip_sel_en}, 32'hB);
  endtask

  task automatic measure_seq(input int exp_gap);
    int t_h = -1;
    int t_l = -1;
    int t_d = -1;
    for (int c = 1; c < 400 && t_l < 0; c++) begin
      @(negedge clk);
      if (sw_hiz_on && t_h < 0) t_h = c;
      if (sw_loz_on && t_l < 0) t_l = c;
      if (seq_done && t_d < 0) t_d = c;
    end
    chk("R3 low-Z gap after high-Z", t_l - t_h, exp_gap);
    chk("R3 seq_done with low-Z", t_d, t_l);
    @(negedge clk);
    chk("R5 powered status word", bus_rdata, 32'h0000_0248);
  endtask

  initial begin
    rst = 1'b1; bus_addr = RA; bus_we = 1'b0; bus_wdata = '0;
    wp_en = 1'b0; fuse_dly = 8'd10;

    do_reset();
    measure_seq(11);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].wd, VECS[i].wp);
      @(negedge clk);
      chk($sformatf("R10 vec%0d readback", i), bus_rdata, VECS[i].rd);
      chk($sformatf("R4 vec%0d switches", i), {30'b0, sw_hiz_on, sw_loz_on},
          {30'b0, VECS[i].hiz, VECS[i].loz});
      chk($sformatf("R8 vec%0d rst/test", i), {30'b0, ip_rst, ip_test},
          {30'b0, VECS[i].rs, VECS[i].tst});
      chk($sformatf("R7 vec%0d clk/sel", i), {30'b0, ip_clk_en, ip_sel_en},
          {30'b0, VECS[i].cke, VECS[i].cke});
    end

    // R9: other address reads zero
    bus_addr = RA + 12'h4;
    @(negedge clk);
    chk("R9 other address", bus_rdata, 32'h0);
    bus_addr = RA;

    // R6: only chip reset clears disable; auto sequence reruns with new fuse count
    fuse_dly = 8'd3;
    do_reset();
    chk("R6 disable cleared by reset", {31'b0, ip_clk_en}, 32'h1);
    measure_seq(4);

    // R3 zero delay
    fuse_dly = 8'd0;
    do_reset();
    measure_seq(1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule